// File: doc/BRIEF.md
# Field-Blanking Line Sequencer

This block produces the per-field timing for a three-gun cutoff servo. Each rising edge of the vertical sync level restarts a count of horizontal sync rising edges. Fixed line numbers in that count set three outputs: a bias window that asks the video path for black-level drive, a grid pulse, and an active-low program pulse. The same line numbers set a 2-bit mode code. The code tells the external sample-and-hold switches whether to stay open, to store a reference (setup) or to measure the correction (sense).

Both sync inputs must already be synchronous to `clk`. The block keeps the previous level of each input and turns every rising edge into a one-cycle strobe. All outputs are decoded from the line count, so they change in the cycle after the edge that moves the count. The block has no data stream, so it has no valid/ready handshake. Every pin is a plain control level.

Top module: `bias_seq`

## Requirements
- R1: After reset, bias_win_o=0, grid_pulse_o=0, prog_pulse_o=1 and mode_o=2'b00 (open). The counter starts saturated, so horizontal edges that arrive before the first vertical edge start no sequence.
- R2: Each rising edge of hsync_lvl advances the line count by exactly one, however many cycles the level stays high. Horizontal edges 1 to 13 of a field leave every output idle.
- R3: bias_win_o goes high with horizontal edge 14 and stays high for 7 lines. It returns low with edge 21.
- R4: Horizontal edges 15, 16 and 17 give mode_o=2'b01 (setup), with grid_pulse_o low and prog_pulse_o high.
- R5: Horizontal edges 18, 19 and 20 give mode_o=2'b10 (sense), grid_pulse_o=1 and prog_pulse_o=0.
- R6: From horizontal edge 21 until the next vertical edge, every output is idle: bias 0, grid 0, program 1, mode open.
- R7: A rising edge of vsync_lvl clears the line count and forces the idle output state, including in the middle of a sequence.
- R8: The count saturates at 255. Further horizontal edges have no effect and leave every output idle.
- R9: When vertical and horizontal rising edges fall in the same cycle, the vertical edge wins and that horizontal edge is not counted.
- R10: mode_o never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync_lvl | input | 1 | Synchronized vertical sync level |
| hsync_lvl | input | 1 | Synchronized horizontal sync level |
| bias_win_o | output | 1 | Black-level request window |
| grid_pulse_o | output | 1 | Grid pulse, high during sense |
| prog_pulse_o | output | 1 | Program pulse, low during sense |
| mode_o | output | 2 | Switch mode: 00 open, 01 setup, 10 sense |

## Verification
Two events can land on the same clock: a vertical edge that clears the count and a horizontal edge that would advance it. The bench raises both sync levels at the same falling clock edge. It then counts exactly 13 further horizontal pulses and checks that the bias window is still low. The 14th pulse must then raise the window, which shows that the shared-cycle horizontal edge was dropped. A second case restarts the field by a vertical edge in the middle of setup. The bench checks the idle state and a clean replay of the schedule.

// File: rtl/bias_seq_pkg.sv
package bias_seq_pkg;
  typedef enum logic [1:0] {
    MODE_OPEN  = 2'b00,
    MODE_SETUP = 2'b01,
    MODE_SENSE = 2'b10
  } seq_mode_e;
endpackage

// File: rtl/bias_seq_edge.sv
module bias_seq_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[g] <= 1'b0;
      else        lvl_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~lvl_q[g];

    // a held level yields one strobe only (R2)
    assert_single_strobe_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/bias_seq_ctr.sv
module bias_seq_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_rise_i,
  input  logic             h_rise_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= CNT_MAX;
    else if (v_rise_i)                   cnt_q <= '0;
    else if (h_rise_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_vclear_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    v_rise_i |=> cnt_q == '0);
  assert_sat_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !v_rise_i) |=> cnt_q == CNT_MAX);
  assert_step_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (h_rise_i && !v_rise_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (!h_rise_i && !v_rise_i) |=> $stable(cnt_q));
endmodule

// File: rtl/bias_seq_dec.sv
module bias_seq_dec
  import bias_seq_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int BIAS_START  = 14,
  parameter int BIAS_LEN    = 7,
  parameter int SETUP_START = 15,
  parameter int PHASE_LEN   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             bias_o,
  output logic             grid_o,
  output logic             prog_o,
  output seq_mode_e        mode_o
);
  localparam logic [CNT_W-1:0] B_LO = CNT_W'(BIAS_START);
  localparam logic [CNT_W-1:0] B_HI = CNT_W'(BIAS_START + BIAS_LEN - 1);
  localparam logic [CNT_W-1:0] S_LO = CNT_W'(SETUP_START);
  localparam logic [CNT_W-1:0] S_HI = CNT_W'(SETUP_START + PHASE_LEN - 1);
  localparam logic [CNT_W-1:0] M_LO = CNT_W'(SETUP_START + PHASE_LEN);
  localparam logic [CNT_W-1:0] M_HI = CNT_W'(SETUP_START + 2 * PHASE_LEN - 1);

  logic in_setup, in_sense;

  always_comb begin
    in_setup = (cnt_i >= S_LO) && (cnt_i <= S_HI);
    in_sense = (cnt_i >= M_LO) && (cnt_i <= M_HI);
    bias_o   = (cnt_i >= B_LO) && (cnt_i <= B_HI);
    grid_o   = in_sense;
    prog_o   = ~in_sense;
    if (in_sense)      mode_o = MODE_SENSE;
    else if (in_setup) mode_o = MODE_SETUP;
    else               mode_o = MODE_OPEN;
  end

  assert_mode_legal_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b11);
  assert_sense_in_window_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    grid_o |-> bias_o);
endmodule

// File: rtl/bias_seq.sv
module bias_seq
  import bias_seq_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int BIAS_START  = 14,
  parameter int BIAS_LEN    = 7,
  parameter int SETUP_START = 15,
  parameter int PHASE_LEN   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vsync_lvl,
  input  logic       hsync_lvl,
  output logic       bias_win_o,
  output logic       grid_pulse_o,
  output logic       prog_pulse_o,
  output logic [1:0] mode_o
);
  logic [1:0]       rise;
  logic [CNT_W-1:0] cnt;
  seq_mode_e        mode;

  bias_seq_edge #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl_i({vsync_lvl, hsync_lvl}), .rise_o(rise)
  );

  bias_seq_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .v_rise_i(rise[1]), .h_rise_i(rise[0]), .cnt_o(cnt)
  );

  bias_seq_dec #(
    .CNT_W(CNT_W), .BIAS_START(BIAS_START), .BIAS_LEN(BIAS_LEN),
    .SETUP_START(SETUP_START), .PHASE_LEN(PHASE_LEN)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt),
    .bias_o(bias_win_o), .grid_o(grid_pulse_o),
    .prog_o(prog_pulse_o), .mode_o(mode)
  );

  assign mode_o = mode;

  assert_vfield_idle_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    rise[1] |=> (!bias_win_o && !grid_pulse_o && prog_pulse_o && mode_o == 2'b00));
endmodule

// File: tb/bias_seq_tb.sv
module bias_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vs = 1'b0, hs = 1'b0;
  logic bias, grid, prog;
  logic [1:0] mode;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bias_seq dut_i (
    .clk(clk), .rst_n(rst_n), .vsync_lvl(vs), .hsync_lvl(hs),
    .bias_win_o(bias), .grid_pulse_o(grid), .prog_pulse_o(prog), .mode_o(mode)
  );

  // {bias, grid, prog, mode} after n horizontal edges of a field
  localparam logic [4:0] IDLE = 5'b00100;
  localparam logic [4:0] EXP_TBL [0:23] = '{
    5'b00100, 5'b00100, 5'b00100, 5'b00100, 5'b00100, 5'b00100,
    5'b00100, 5'b00100, 5'b00100, 5'b00100, 5'b00100, 5'b00100,
    5'b00100, 5'b00100, 5'b10100, 5'b10101, 5'b10101, 5'b10101,
    5'b11010, 5'b11010, 5'b11010, 5'b00100, 5'b00100, 5'b00100
  };

  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {bias, grid, prog, mode};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hpulse(input int width);
    @(negedge clk) hs = 1'b1;
    repeat (width) @(negedge clk);
    hs = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic vpulse(input bit with_h);
    @(negedge clk) begin vs = 1'b1; if (with_h) hs = 1'b1; end
    repeat (3) @(negedge clk);
    vs = 1'b0; hs = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", IDLE);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) hpulse(2);
    chk("R1 no field before vsync", IDLE);

    // table walk: R2 R3 R4 R5 R6
    vpulse(0);
    chk("R7 after vsync", EXP_TBL[0]);
    for (int n = 1; n < 24; n++) begin
      hpulse((n % 4) + 1);
      chk($sformatf("R2-R6 table line %0d", n), EXP_TBL[n]);
    end

    // R7: restart mid-setup
    vpulse(0);
    for (int n = 1; n <= 16; n++) hpulse(1);
    chk("R4 setup before restart", 5'b10101);
    vpulse(0);
    chk("R7 restart idle", IDLE);
    for (int n = 1; n <= 14; n++) hpulse(1);
    chk("R7 replay bias at 14", 5'b10100);

    // R9: simultaneous vertical and horizontal rise
    vpulse(1);
    chk("R9 clear", IDLE);
    for (int n = 1; n <= 13; n++) hpulse(1);
    chk("R9 edge 13 idle", IDLE);
    hpulse(1);
    chk("R9 edge 14 bias", 5'b10100);

    // R8: saturation, 270 edges would wrap to 14 without it
    vpulse(0);
    for (int n = 1; n <= 270; n++) hpulse(1);
    chk("R8 saturated idle", IDLE);
    for (int n = 1; n <= 20; n++) hpulse(1);
    chk("R8 still idle", IDLE);
    chk("R10 mode legal", {bias, grid, prog, (mode == 2'b11) ? 2'b00 : mode});

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule